// File: doc/BRIEF.md
# Serial Magnitude Comparator

This block decides the ordering of two unsigned binary operands that are presented one bit pair per clock, most significant bit first. A caller raises `start` together with the first bit pair, then keeps presenting pairs on cycles where `valid` is high. After each accepted pair, the three result outputs give the ordering of the operand prefixes received so far. Once the last pair has been accepted, they therefore give the ordering of the complete operands. Cycles with `valid` low may be inserted anywhere, so a slow producer can feed the block without extra buffering.

The ordering is held in a two-bit state. The code 00 means equal and is also the reset value. Code 01 means X greater and code 10 means X less. Code 11 is never entered.

The block can optionally build a parameterised ripple array of identical combinational cells. This array applies the same per-bit transition function to a shadow record of the received bits, which gives an independent second view of the same decision. That view exists only to feed an internal consistency assertion and drives no output.

Top module: `serial_mag_cmp`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the block enters the equal state: `x_eq_y`=1, `x_lt_y`=0, `x_gt_y`=0 from that edge on.
- R2: After reset, exactly one of `x_lt_y`, `x_eq_y`, `x_gt_y` is high in every cycle.
- R3: In the equal state, an accepted pair with x=1 and y=0 makes `x_gt_y`=1 after that clock edge.
- R4: In the equal state, an accepted pair with x=0 and y=1 makes `x_lt_y`=1 after that clock edge.
- R5: In the equal state, an accepted pair with equal bits keeps `x_eq_y`=1.
- R6: Once `x_gt_y` or `x_lt_y` is high, it stays high for any later bit pairs until `start` or reset.
- R7: A cycle with `valid` low and `start` low leaves all outputs unchanged, whatever `x_bit` and `y_bit` carry.
- R8: `start` with `valid` low returns the block to the equal state at the next edge.
- R9: `start` with `valid` high discards the earlier result and applies that bit pair to a fresh equal state, so that operand pairs can follow back to back.
- R10: After all bits of an operand pair of any width from 1 to 64 have been accepted, the outputs equal the unsigned arithmetic comparison of the two operands.
- R11: Reset takes priority over `start` and `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new operand pair; may coincide with its first bit |
| valid | input | 1 | The bit pair on `x_bit`/`y_bit` is accepted this cycle |
| x_bit | input | 1 | Current bit of operand X, MSB first |
| y_bit | input | 1 | Current bit of operand Y, MSB first |
| x_lt_y | output | 1 | X prefix is less than Y prefix |
| x_eq_y | output | 1 | Prefixes are equal |
| x_gt_y | output | 1 | X prefix is greater than Y prefix |

## Verification
The assertions assume that `start`, `valid` and the data bits are free of unknown values after reset. The shadow-array cross-check also assumes that an operand does not exceed the recorded history depth; past that depth the check switches itself off rather than assuming that inputs stop. The stimulus drives every input to a known value on every cycle, including idle cycles, where the data bits are random. It begins each operand with `start`, and it keeps operand widths at or below 64 while the default history depth covers the short operands fully.

// File: rtl/smc_pkg.sv
// Package: shared state encoding and the single-bit transition function
// used by both the serial state register and the combinational array.
// Assumes operands are scanned from the most significant bit downward.
package smc_pkg;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_GT  = 2'b01,
        CMP_LT  = 2'b10,
        CMP_BAD = 2'b11
    } cmp_state_e;

    // One step of the comparison: decided states lock, illegal code recovers.
    function automatic cmp_state_e cmp_step(cmp_state_e cur, logic xb, logic yb);
        cmp_state_e nxt;
        unique case (cur)
            CMP_EQ: begin
                unique case ({xb, yb})
                    2'b10:   nxt = CMP_GT;
                    2'b01:   nxt = CMP_LT;
                    default: nxt = CMP_EQ;
                endcase
            end
            CMP_GT:  nxt = CMP_GT;
            CMP_LT:  nxt = CMP_LT;
            default: nxt = CMP_EQ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/smc_cell.sv
// Module: smc_cell
// One comparison cell: maps the incoming ordering and one bit pair to the
// outgoing ordering. Purely combinational; assumes known inputs.
module smc_cell
    import smc_pkg::*;
(
    input  cmp_state_e s_in,
    input  logic       x_b,
    input  logic       y_b,
    output cmp_state_e s_out
);

    // Apply the shared transition function.
    always_comb begin
        s_out = cmp_step(s_in, x_b, y_b);
    end

endmodule

// File: rtl/smc_state_reg.sv
// Module: smc_state_reg
// Holds the running ordering of the operand prefixes. Advances only on
// accepted bit pairs; start clears to equal (or folds in a same-cycle pair).
// Assumes synchronous active-low reset and known control inputs.
module smc_state_reg
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       valid,
    input  logic       x_bit,
    input  logic       y_bit,
    output cmp_state_e state_q
);

    cmp_state_e base_s;
    cmp_state_e stepped_s;
    cmp_state_e state_d;

    // Pick the state the incoming pair is applied to.
    always_comb begin
        base_s = start ? CMP_EQ : state_q;
    end

    smc_cell u_step (
        .s_in  (base_s),
        .x_b   (x_bit),
        .y_b   (y_bit),
        .s_out (stepped_s)
    );

    // Next-state selection: accept, restart, recover or hold.
    always_comb begin
        if (valid)                  state_d = stepped_s;
        else if (start)             state_d = CMP_EQ;
        else if (state_q == CMP_BAD) state_d = CMP_EQ;
        else                        state_d = state_q;
    end

    // State register with synchronous reset to the equal code.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_EQ;
        else        state_q <= state_d;
    end

    AST_LOCK_GT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_GT && !start) |=> (state_q == CMP_GT)); // R6

    AST_LOCK_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_LT && !start) |=> (state_q == CMP_LT)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !start) |=> $stable(state_q)); // R7

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid) |=> (state_q == CMP_EQ)); // R8

    AST_FIRST_GT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (start || state_q == CMP_EQ) && x_bit && !y_bit) |=> (state_q == CMP_GT)); // R3

    AST_FIRST_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (start || state_q == CMP_EQ) && !x_bit && y_bit) |=> (state_q == CMP_LT)); // R4

    AST_RESET_EQ: assert property (@(posedge clk)
        !rst_n |=> (state_q == CMP_EQ)); // R1

endmodule

// File: rtl/smc_decode.sv
// Module: smc_decode
// Turns the two-bit ordering code into three result flags. The unused
// code drives all flags low; it is never held past one clock.
module smc_decode
    import smc_pkg::*;
(
    input  cmp_state_e state,
    output logic       lt,
    output logic       eq,
    output logic       gt
);

    // Decode the ordering code into flags.
    always_comb begin
        lt = (state == CMP_LT);
        eq = (state == CMP_EQ);
        gt = (state == CMP_GT);
    end

endmodule

// File: rtl/smc_cell_array.sv
// Module: smc_cell_array
// Ripple chain of identical cells comparing two parallel words, MSB first.
// Stage 0 starts from the equal code. Assumes NBITS >= 1.
module smc_cell_array
    import smc_pkg::*;
#(
    parameter int unsigned NBITS = 16
) (
    input  logic [NBITS-1:0] x_word,
    input  logic [NBITS-1:0] y_word,
    output cmp_state_e       result
);

    cmp_state_e chain [0:NBITS];

    // Seed the chain at the most significant end.
    always_comb begin
        chain[0] = CMP_EQ;
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        smc_cell u_cell (
            .s_in  (chain[i]),
            .x_b   (x_word[NBITS-1-i]),
            .y_b   (y_word[NBITS-1-i]),
            .s_out (chain[i+1])
        );
    end

    // Expose the least significant end of the chain.
    always_comb begin
        result = chain[NBITS];
    end

endmodule

// File: rtl/serial_mag_cmp.sv
// Module: serial_mag_cmp (top)
// Serial MSB-first unsigned magnitude comparator. ARRAY_VIEW adds a shadow
// history and a combinational cell array whose verdict must match the
// serial state while the operand fits in VIEW_BITS. Assumes VIEW_BITS >= 2.
module serial_mag_cmp
    import smc_pkg::*;
#(
    parameter bit          ARRAY_VIEW = 1'b1,
    parameter int unsigned VIEW_BITS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    input  logic x_bit,
    input  logic y_bit,
    output logic x_lt_y,
    output logic x_eq_y,
    output logic x_gt_y
);

    cmp_state_e state_q;

    smc_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .valid   (valid),
        .x_bit   (x_bit),
        .y_bit   (y_bit),
        .state_q (state_q)
    );

    smc_decode u_dec (
        .state (state_q),
        .lt    (x_lt_y),
        .eq    (x_eq_y),
        .gt    (x_gt_y)
    );

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({x_lt_y, x_eq_y, x_gt_y}) == 1); // R2

    if (ARRAY_VIEW) begin : g_view
        localparam int unsigned CW = $clog2(VIEW_BITS + 2);
        localparam logic [CW-1:0] FULL = CW'(VIEW_BITS);

        logic [VIEW_BITS-1:0] x_hist;
        logic [VIEW_BITS-1:0] y_hist;
        logic [CW-1:0]        seen;
        cmp_state_e           arr_state;

        // Record accepted bits; start discards the previous operand.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                x_hist <= '0;
                y_hist <= '0;
            end else if (valid) begin
                x_hist <= start ? VIEW_BITS'(x_bit) : {x_hist[VIEW_BITS-2:0], x_bit};
                y_hist <= start ? VIEW_BITS'(y_bit) : {y_hist[VIEW_BITS-2:0], y_bit};
            end else if (start) begin
                x_hist <= '0;
                y_hist <= '0;
            end
        end

        // Count accepted bits, saturating one past the history depth.
        always_ff @(posedge clk) begin
            if (!rst_n)               seen <= '0;
            else if (valid && start)  seen <= CW'(1);
            else if (start)           seen <= '0;
            else if (valid && seen <= FULL) seen <= seen + 1'b1;
        end

        smc_cell_array #(.NBITS(VIEW_BITS)) u_arr (
            .x_word (x_hist),
            .y_word (y_hist),
            .result (arr_state)
        );

        AST_ARRAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (seen <= FULL) |-> (arr_state == state_q)); // R10
    end

endmodule

// File: tb/serial_mag_cmp_tb.sv
module serial_mag_cmp_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  lt;
        logic  eq;
        logic  gt;
        int    due;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic valid = 1'b0;
    logic x_bit = 1'b0;
    logic y_bit = 1'b0;
    logic x_lt_y, x_eq_y, x_gt_y;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    exp_t sb_q[$];

    serial_mag_cmp u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .valid  (valid),
        .x_bit  (x_bit),
        .y_bit  (y_bit),
        .x_lt_y (x_lt_y),
        .x_eq_y (x_eq_y),
        .x_gt_y (x_gt_y)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: one-hot check every cycle, then pop due expectations.
    always @(negedge clk) begin
        if (cyc >= 3 && rst_n) begin
            checks++;
            if ($countones({x_lt_y, x_eq_y, x_gt_y}) != 1) begin
                failures++;
                $display("FAIL R2 cyc=%0d actual lt/eq/gt=%b%b%b expected exactly one high",
                         cyc, x_lt_y, x_eq_y, x_gt_y);
            end
        end
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (e.due != cyc || x_lt_y !== e.lt || x_eq_y !== e.eq || x_gt_y !== e.gt) begin
                failures++;
                $display("FAIL %s cyc=%0d actual lt/eq/gt=%b%b%b expected %b%b%b",
                         e.tag, cyc, x_lt_y, x_eq_y, x_gt_y, e.lt, e.eq, e.gt);
            end
        end
    end

    task automatic drive(input logic rn, input logic s, input logic v,
                         input logic xb, input logic yb);
        @(negedge clk);
        #1;
        rst_n = rn;
        start = s;
        valid = v;
        x_bit = xb;
        y_bit = yb;
    endtask

    // Push an expectation for the outputs after the next rising edge.
    task automatic expect_res(input logic lt, input logic eq, input logic gt, input string tag);
        exp_t e;
        e.lt = lt; e.eq = eq; e.gt = gt; e.due = cyc + 1; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic run_operand(input int w, input logic [63:0] xv, input logic [63:0] yv,
                               input string tag);
        logic [63:0] mask;
        logic [63:0] xm, ym;
        for (int i = w - 1; i >= 0; i--) begin
            if (i != w - 1 && $urandom_range(0, 3) == 0)
                drive(1'b1, 1'b0, 1'b0, 1'($urandom), 1'($urandom));
            drive(1'b1, (i == w - 1), 1'b1, xv[i], yv[i]);
        end
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        xm = xv & mask;
        ym = yv & mask;
        expect_res(xm < ym, xm == ym, xm > ym, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 / R11: reset wins over start and a deciding pair.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_res(1'b0, 1'b1, 1'b0, "R1_reset");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        expect_res(1'b0, 1'b1, 1'b0, "R11_reset_priority");

        // R3 / R9: start with a pair decides X greater; R6 lock.
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_res(1'b0, 1'b0, 1'b1, "R3_gt_R9");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_res(1'b0, 1'b0, 1'b1, "R6_gt_lock");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_res(1'b0, 1'b0, 1'b1, "R6_gt_lock2");

        // R8: start alone clears; R4 then R6 lock on less.
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_res(1'b0, 1'b1, 1'b0, "R8_start_clear");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_res(1'b1, 1'b0, 1'b0, "R4_lt");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_res(1'b1, 1'b0, 1'b0, "R6_lt_lock");

        // R9: back-to-back restart with a pair discards the old verdict.
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        expect_res(1'b0, 1'b1, 1'b0, "R9_restart_eq");
        // R5: equal pairs keep equal.
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_res(1'b0, 1'b1, 1'b0, "R5_eq_00");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        expect_res(1'b0, 1'b1, 1'b0, "R5_eq_11");

        // R7: idle cycles with deciding data do not move the state.
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_res(1'b0, 1'b1, 1'b0, "R7_idle_eq");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_res(1'b0, 1'b1, 1'b0, "R7_idle_eq2");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_res(1'b0, 1'b0, 1'b1, "R3_gt_after_eq");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_res(1'b0, 1'b0, 1'b1, "R7_idle_gt");

        // R10: corner operands.
        run_operand(1, 64'd0, 64'd0, "R10_w1_eq");
        run_operand(1, 64'd1, 64'd0, "R10_w1_gt");
        run_operand(1, 64'd0, 64'd1, "R10_w1_lt");
        run_operand(64, '1, '1, "R10_w64_ones");
        run_operand(64, 64'd0, '1, "R10_w64_zero_max");
        run_operand(64, '1, 64'hFFFF_FFFF_FFFF_FFFE, "R10_w64_lsb");
        run_operand(16, 16'h8000, 16'h7FFF, "R10_w16_msb");
        run_operand(20, 64'h0_1234, 64'h0_1235, "R10_w20_lsb");
        run_operand(5, 64'hFF_FFFF_FFE5, 64'h05, "R10_w5_mask");

        // R10: random widths and operands, with some near-equal pairs.
        for (int n = 0; n < 60; n++) begin
            int w;
            logic [63:0] a, b;
            w = $urandom_range(1, 64);
            a = {$urandom, $urandom};
            b = ($urandom_range(0, 2) == 0) ? (a ^ (64'd1 << $urandom_range(0, w - 1)))
                                            : {$urandom, $urandom};
            run_operand(w, a, b, "R10_random");
        end

        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule